// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides which event advances a timer's prescaler. It turns one of several clock sources into a count-enable that is one clock wide. The first source is the internal clock, which enables a count on every cycle. The second is external-clock mode 1: rising edges of a trigger chosen from peer-timer lines and conditioned channel pins. The third is external-clock mode 2: rising edges of a conditioned external trigger pin. Everything runs on the internal clock. The asynchronous pins are first brought into that domain by a two-stage synchronizer.

The external trigger pin is synchronized, optionally inverted, then divided by 1, 2, 4 or 8 (counted in rising edges). After that it is cleaned by a digital filter. Each of the two channel pins also has its own filter. Channel 1 offers both its filtered level and an any-edge event. Channel 2 offers its filtered level, with a bit that picks which of its edges counts. A filter with threshold N changes its output only after its input has disagreed with that output for N consecutive cycles. N equal to 0 behaves like 1.

Top module: `tick_source_select`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `countEn` is 0.
- R2: When `extTrigClkEn` is 0 and `modeSel` is not 3'b111, `countEn` is 1 on every cycle from the first clock edge after reset release.
- R3: When `extTrigClkEn` is 1, `countEn` pulses for one cycle on each rising edge of the filtered external trigger. This takes priority over `modeSel`, so activity on the mode-1 trigger is ignored.
- R4: With `extTrigInvert` = 1 the external trigger path counts falling edges of `extTrigPin`, and a rising pin edge gives no count.
- R5: `extTrigDiv` = k passes one rising edge for every 2^k rising edges of the (possibly inverted) synchronized pin. The encoding is 0 for /1, 1 for /2, 2 for /4 and 3 for /8.
- R6: A pin level change reaches the edge logic only after it has been held for `Filt` consecutive samples (0 counts as 1). Shorter glitches give no count.
- R7: With `modeSel` = 3'b111 and `trigSel` = 3'b0xx, `countEn` is 1 in each cycle where `peerTrig[trigSel[1:0]]` is high and was low in the previous cycle. The other peer lines are ignored, and peer lines are not resynchronized.
- R8: `trigSel` = 3'b100 counts both edges of filtered channel 1.
- R9: `trigSel` = 3'b101 counts rising edges of filtered channel 1.
- R10: `trigSel` = 3'b110 counts edges of filtered channel 2. These are rising edges when `ch2Falling` = 0 and falling edges when it is 1.
- R11: `trigSel` = 3'b111 counts rising edges of the fully conditioned external trigger (inversion, divider, filter).
- R12: With the external trigger filter at 0 and the divider at /1, a pin rise that is in place before edge E0 makes `countEn` high for exactly the one cycle after edge E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extTrigPin | input | 1 | External trigger pin, asynchronous |
| ch1Pin | input | 1 | Channel 1 pin, asynchronous |
| ch2Pin | input | 1 | Channel 2 pin, asynchronous |
| peerTrig | input | ITR_N | Trigger lines from other timers, synchronous |
| extTrigClkEn | input | 1 | Selects external-clock mode 2 |
| modeSel | input | 3 | 3'b111 selects external-clock mode 1, other values select the internal clock |
| trigSel | input | 3 | Trigger source for mode 1 |
| extTrigInvert | input | 1 | Inverts the external trigger |
| extTrigDiv | input | DIV_W | External trigger divide exponent |
| extTrigFilt | input | FILT_W | External trigger filter threshold |
| ch1Filt | input | FILT_W | Channel 1 filter threshold |
| ch2Filt | input | FILT_W | Channel 2 filter threshold |
| ch2Falling | input | 1 | Channel 2 counts falling edges |
| countEn | output | 1 | One-cycle prescaler count enable |

## Verification
The external-trigger path and the mode-1 trigger path can produce an event in the same cycle. In that case only the external-trigger event may count. The bench provokes this by enabling mode 2 while `modeSel` still reads 3'b111 and `trigSel` points at a peer line. It then toggles that peer line in lockstep with the external trigger pin, and later pulses channel 1 with the trigger select on channel 1. It judges the result by counting `countEn` pulses over a window against the number of external edges alone. A behavioural reference model compared on every cycle also catches any extra or shifted pulse.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam logic [2:0] MODE_EXT_TRIG = 3'b111;

  typedef enum logic [2:0] {
    SRC_PEER0    = 3'b000,
    SRC_PEER1    = 3'b001,
    SRC_PEER2    = 3'b010,
    SRC_PEER3    = 3'b011,
    SRC_CH1_ANY  = 3'b100,
    SRC_CH1_LVL  = 3'b101,
    SRC_CH2_LVL  = 3'b110,
    SRC_EXT_LVL  = 3'b111
  } trig_src_e;

  typedef struct packed {
    logic      tickAlways;
    logic      tickExt;
    logic      tickTrig;
    trig_src_e trigSrc;
  } tick_strobe_t;

endpackage

// File: rtl/tsel_sync2.sv
module tsel_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/tsel_filter.sv
module tsel_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             din,
  input  logic [CNT_W-1:0] thresh,
  output logic             dout
);
  logic [CNT_W-1:0] runLen;
  logic [CNT_W:0]   need;
  logic [CNT_W:0]   nextLen;

  always_comb begin
    need    = (thresh == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, thresh};
    nextLen = {1'b0, runLen} + {{CNT_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      dout   <= 1'b0;
    end else if (din == dout) begin
      runLen <= '0;
    end else if (nextLen >= need) begin
      dout   <= din;
      runLen <= '0;
    end else begin
      runLen <= nextLen[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tsel_ext_cond.sv
module tsel_ext_cond #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             invert,
  input  logic [DIV_W-1:0] divExp,
  output logic             divOut
);
  localparam int DCNT_W = (1 << DIV_W) - 1;

  logic              polarized;
  logic              prevPol;
  logic              riseSeen;
  logic [DCNT_W-1:0] edgeCnt;
  logic [DIV_W-1:0]  tapIdx;

  always_comb begin
    polarized = syncIn ^ invert;
    riseSeen  = polarized & ~prevPol;
    tapIdx    = divExp - {{(DIV_W-1){1'b0}}, 1'b1};
    divOut    = (divExp == '0) ? polarized : edgeCnt[tapIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPol <= 1'b0;
      edgeCnt <= '0;
    end else begin
      prevPol <= polarized;
      if (riseSeen) edgeCnt <= edgeCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsel_control.sv
module tsel_control
  import tsel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         extTrigClkEn,
  input  logic [2:0]   modeSel,
  input  logic [2:0]   trigSel,
  output tick_strobe_t strobe
);
  logic liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= 1'b1;
  end

  always_comb begin
    strobe.trigSrc    = trig_src_e'(trigSel);
    strobe.tickExt    = liveQ & extTrigClkEn;
    strobe.tickTrig   = liveQ & ~extTrigClkEn & (modeSel == MODE_EXT_TRIG);
    strobe.tickAlways = liveQ & ~extTrigClkEn & (modeSel != MODE_EXT_TRIG);
  end
endmodule

// File: rtl/tsel_datapath.sv
module tsel_datapath
  import tsel_pkg::*;
#(
  parameter int ITR_N  = 4,
  parameter int FILT_W = 4,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTrigPin,
  input  logic              ch1Pin,
  input  logic              ch2Pin,
  input  logic [ITR_N-1:0]  peerTrig,
  input  logic              extTrigInvert,
  input  logic [DIV_W-1:0]  extTrigDiv,
  input  logic [FILT_W-1:0] extTrigFilt,
  input  logic [FILT_W-1:0] ch1Filt,
  input  logic [FILT_W-1:0] ch2Filt,
  input  logic              ch2Falling,
  input  tick_strobe_t      strobe,
  output logic              countEn
);
  localparam int PIN_N     = 3;
  localparam int ITR_SEL_W = (ITR_N > 1) ? $clog2(ITR_N) : 1;

  logic [PIN_N-1:0]  pinSync;
  logic [PIN_N-1:0]  filtIn;
  logic [PIN_N-1:0]  filtOut;
  logic [FILT_W-1:0] filtThr [PIN_N];
  logic              extDiv;
  logic              extPrev, ch1Prev, ch2Prev;
  logic [ITR_N-1:0]  peerPrev;
  logic [ITR_N-1:0]  peerRise;
  logic              extEdge, ch1Any, ch1Rise, ch2Edge, trigPulse;

  tsel_sync2 #(.W(PIN_N)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({ch2Pin, ch1Pin, extTrigPin}),
    .syncOut (pinSync)
  );

  tsel_ext_cond #(.DIV_W(DIV_W)) u_extCond (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (pinSync[0]),
    .invert (extTrigInvert),
    .divExp (extTrigDiv),
    .divOut (extDiv)
  );

  always_comb begin
    filtIn     = {pinSync[2], pinSync[1], extDiv};
    filtThr[0] = extTrigFilt;
    filtThr[1] = ch1Filt;
    filtThr[2] = ch2Filt;
  end

  for (genvar gi = 0; gi < PIN_N; gi++) begin : g_filt
    tsel_filter #(.CNT_W(FILT_W)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .din    (filtIn[gi]),
      .thresh (filtThr[gi]),
      .dout   (filtOut[gi])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      ch1Prev <= 1'b0;
      ch2Prev <= 1'b0;
    end else begin
      extPrev <= filtOut[0];
      ch1Prev <= filtOut[1];
      ch2Prev <= filtOut[2];
    end
  end

  always_ff @(posedge clk) begin
    peerPrev <= peerTrig;
  end

  always_comb begin
    extEdge  = filtOut[0] & ~extPrev;
    ch1Any   = filtOut[1] ^ ch1Prev;
    ch1Rise  = filtOut[1] & ~ch1Prev;
    ch2Edge  = ch2Falling ? (~filtOut[2] & ch2Prev) : (filtOut[2] & ~ch2Prev);
    peerRise = peerTrig & ~peerPrev;
    case (strobe.trigSrc)
      SRC_CH1_ANY: trigPulse = ch1Any;
      SRC_CH1_LVL: trigPulse = ch1Rise;
      SRC_CH2_LVL: trigPulse = ch2Edge;
      SRC_EXT_LVL: trigPulse = extEdge;
      default:     trigPulse = peerRise[strobe.trigSrc[ITR_SEL_W-1:0]];
    endcase
    countEn = strobe.tickAlways
            | (strobe.tickExt  & extEdge)
            | (strobe.tickTrig & trigPulse);
  end
endmodule

// File: rtl/tick_source_select.sv
module tick_source_select
  import tsel_pkg::*;
#(
  parameter int ITR_N  = 4,
  parameter int FILT_W = 4,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTrigPin,
  input  logic              ch1Pin,
  input  logic              ch2Pin,
  input  logic [ITR_N-1:0]  peerTrig,
  input  logic              extTrigClkEn,
  input  logic [2:0]        modeSel,
  input  logic [2:0]        trigSel,
  input  logic              extTrigInvert,
  input  logic [DIV_W-1:0]  extTrigDiv,
  input  logic [FILT_W-1:0] extTrigFilt,
  input  logic [FILT_W-1:0] ch1Filt,
  input  logic [FILT_W-1:0] ch2Filt,
  input  logic              ch2Falling,
  output logic              countEn
);
  tick_strobe_t strobe;

  tsel_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .extTrigClkEn (extTrigClkEn),
    .modeSel      (modeSel),
    .trigSel      (trigSel),
    .strobe       (strobe)
  );

  tsel_datapath #(
    .ITR_N  (ITR_N),
    .FILT_W (FILT_W),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .extTrigPin    (extTrigPin),
    .ch1Pin        (ch1Pin),
    .ch2Pin        (ch2Pin),
    .peerTrig      (peerTrig),
    .extTrigInvert (extTrigInvert),
    .extTrigDiv    (extTrigDiv),
    .extTrigFilt   (extTrigFilt),
    .ch1Filt       (ch1Filt),
    .ch2Filt       (ch2Filt),
    .ch2Falling    (ch2Falling),
    .strobe        (strobe),
    .countEn       (countEn)
  );
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int ITR_N = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             extTrigClkEn,
  input logic [2:0]       modeSel,
  input logic [2:0]       trigSel,
  input logic [ITR_N-1:0] peerTrig,
  input logic             countEn
);
  localparam int ITR_SEL_W = (ITR_N > 1) ? $clog2(ITR_N) : 1;
  localparam logic [ITR_N-1:0] ONE_HOT0 = {{(ITR_N-1){1'b0}}, 1'b1};

  always @(negedge clk) begin
    if (!rstN) AST_QUIET_IN_RESET: assert (!countEn); // R1
  end

  AST_INTERNAL_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !extTrigClkEn && modeSel != 3'b111) |-> countEn); // R2

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (extTrigClkEn && countEn) |=> !(extTrigClkEn && countEn)); // R3

  AST_PEER_RISING: assert property (@(posedge clk) disable iff (!rstN)
    (!extTrigClkEn && modeSel == 3'b111 && !trigSel[2] && countEn)
      |-> (((peerTrig & ~$past(peerTrig)) & (ONE_HOT0 << trigSel[ITR_SEL_W-1:0])) != '0)); // R7

  AST_LEVEL_SRC_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (!extTrigClkEn && modeSel == 3'b111 && trigSel != 3'b100 && trigSel[2] && countEn)
      |=> (!countEn || !$stable(trigSel) || extTrigClkEn || modeSel != 3'b111)); // R9
endmodule

bind tick_source_select tsel_checker #(.ITR_N(ITR_N)) u_tselChk (
  .clk          (clk),
  .rstN         (rstN),
  .extTrigClkEn (extTrigClkEn),
  .modeSel      (modeSel),
  .trigSel      (trigSel),
  .peerTrig     (peerTrig),
  .countEn      (countEn)
);

// File: tb/tick_source_select_test.sv
module tick_source_select_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       extTrigPin = 0, ch1Pin = 0, ch2Pin = 0;
  logic [3:0] peerTrig = '0;
  logic       extTrigClkEn = 0;
  logic [2:0] modeSel = '0, trigSel = '0;
  logic       extTrigInvert = 0;
  logic [1:0] extTrigDiv = '0;
  logic [3:0] extTrigFilt = '0, ch1Filt = '0, ch2Filt = '0;
  logic       ch2Falling = 0;
  logic       countEn;

  tick_source_select uut (
    .clk(clk), .rstN(rstN), .extTrigPin(extTrigPin), .ch1Pin(ch1Pin), .ch2Pin(ch2Pin),
    .peerTrig(peerTrig), .extTrigClkEn(extTrigClkEn), .modeSel(modeSel), .trigSel(trigSel),
    .extTrigInvert(extTrigInvert), .extTrigDiv(extTrigDiv), .extTrigFilt(extTrigFilt),
    .ch1Filt(ch1Filt), .ch2Filt(ch2Filt), .ch2Falling(ch2Falling), .countEn(countEn)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string curReq = "R1";
  bit    winOn = 0;
  int    winCnt = 0;

  // Reference model state
  bit       mS1[3], mS2[3], mF[3];
  int       mFc[3];
  bit       mPrevInv, mExtP, mCh1P, mCh2P, mLive;
  int       mDiv;
  bit [3:0] mPeerP;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit modelExp();
    if (!mLive) return 1'b0;
    if (extTrigClkEn) return mF[0] & ~mExtP;
    if (modeSel != 3'b111) return 1'b1;
    case (trigSel)
      3'd4: return mF[1] ^ mCh1P;
      3'd5: return mF[1] & ~mCh1P;
      3'd6: return ch2Falling ? (~mF[2] & mCh2P) : (mF[2] & ~mCh2P);
      3'd7: return mF[0] & ~mExtP;
      default: return peerTrig[trigSel[1:0]] & ~mPeerP[trigSel[1:0]];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mS1[i] = 0; mS2[i] = 0; mF[i] = 0; mFc[i] = 0;
      end
      mPrevInv = 0; mExtP = 0; mCh1P = 0; mCh2P = 0; mLive = 0; mDiv = 0;
    end else begin
      bit inv, rise, dOut;
      bit fin[3];
      int fld[3];
      inv  = mS2[0] ^ extTrigInvert;
      rise = inv & ~mPrevInv;
      dOut = (extTrigDiv == 0) ? inv : bit'((mDiv >> (int'(extTrigDiv) - 1)) & 1);
      fin[0] = dOut; fin[1] = mS2[1]; fin[2] = mS2[2];
      fld[0] = extTrigFilt; fld[1] = ch1Filt; fld[2] = ch2Filt;
      mExtP = mF[0]; mCh1P = mF[1]; mCh2P = mF[2];
      for (int i = 0; i < 3; i++) begin
        int need;
        need = (fld[i] == 0) ? 1 : fld[i];
        if (fin[i] == mF[i]) mFc[i] = 0;
        else if (mFc[i] + 1 >= need) begin mF[i] = fin[i]; mFc[i] = 0; end
        else mFc[i]++;
      end
      mPrevInv = inv;
      if (rise) mDiv = (mDiv + 1) % 8;
      mS2 = mS1;
      mS1[0] = extTrigPin; mS1[1] = ch1Pin; mS1[2] = ch2Pin;
      mLive = 1;
    end
    mPeerP = peerTrig;
  end

  always @(negedge clk) begin
    #5;
    check(countEn === modelExp(), curReq, int'(countEn), int'(modelExp()), "per-cycle model compare");
    if (winOn) winCnt += int'(countEn);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int which, input bit v);
    case (which)
      0: extTrigPin = v;
      1: ch1Pin = v;
      2: ch2Pin = v;
      default: peerTrig[which-3] = v;
    endcase
  endtask

  task automatic pulses(input int which, input int n, input int hi, input int lo, input bit withPeer0);
    for (int p = 0; p < n; p++) begin
      setPin(which, 1); if (withPeer0) peerTrig[0] = 1;
      tick(hi);
      setPin(which, 0); if (withPeer0) peerTrig[0] = 0;
      tick(lo);
    end
  endtask

  task automatic winStart();
    winCnt = 0; winOn = 1;
  endtask

  task automatic winEnd(input int exp, input string req, input string what);
    winOn = 0;
    check(winCnt == exp, req, winCnt, exp, what);
  endtask

  initial begin
    tick(3);
    #6 check(countEn == 0, "R1", int'(countEn), 0, "quiet during reset");
    @(negedge clk) rstN = 1;
    #6 check(countEn == 0, "R1", int'(countEn), 0, "quiet first cycle after reset");

    curReq = "R2";
    tick(2);
    winStart(); tick(20); winEnd(20, "R2", "internal clock every cycle");
    modeSel = 3'b011;
    winStart(); tick(10); winEnd(10, "R2", "non-trigger mode value counts every cycle");

    curReq = "R12";
    extTrigClkEn = 1; modeSel = 3'b111; trigSel = 3'b000;
    tick(6);
    @(negedge clk) extTrigPin = 1;
    @(negedge clk); #6 check(countEn == 0, "R12", int'(countEn), 0, "no pulse after E0");
    @(negedge clk); #6 check(countEn == 0, "R12", int'(countEn), 0, "no pulse after E1");
    @(negedge clk); #6 check(countEn == 1, "R12", int'(countEn), 1, "pulse after E2");
    @(negedge clk); #6 check(countEn == 0, "R12", int'(countEn), 0, "pulse one cycle wide");
    @(negedge clk) extTrigPin = 0;
    tick(6);

    curReq = "R3";
    winStart(); pulses(0, 5, 4, 4, 1); tick(6); winEnd(5, "R3", "ext trigger counts, peer edges ignored");
    trigSel = 3'b101;
    winStart(); pulses(1, 3, 4, 4, 0); tick(6); winEnd(0, "R3", "channel 1 ignored in mode 2");

    curReq = "R4";
    extTrigInvert = 1; tick(8);
    winStart(); extTrigPin = 1; tick(8); winEnd(0, "R4", "rising pin edge not counted when inverted");
    winStart(); extTrigPin = 0; tick(8); winEnd(1, "R4", "falling pin edge counted when inverted");
    extTrigInvert = 0; tick(8);

    curReq = "R5";
    extTrigDiv = 2'd2; tick(8);
    winStart(); pulses(0, 8, 3, 3, 0); tick(8); winEnd(2, "R5", "divide by 4");
    extTrigDiv = 2'd3; tick(8);
    winStart(); pulses(0, 8, 3, 3, 0); tick(8); winEnd(1, "R5", "divide by 8");
    extTrigDiv = 2'd1; tick(8);
    winStart(); pulses(0, 8, 3, 3, 0); tick(8); winEnd(4, "R5", "divide by 2");
    extTrigDiv = 2'd0; tick(8);

    curReq = "R6";
    extTrigFilt = 4'd5; tick(8);
    winStart(); pulses(0, 1, 3, 12, 0); winEnd(0, "R6", "short glitch filtered out");
    winStart(); pulses(0, 1, 8, 12, 0); winEnd(1, "R6", "long pulse passes filter");
    extTrigFilt = 4'd0; tick(4);

    curReq = "R7";
    extTrigClkEn = 0; modeSel = 3'b111; trigSel = 3'b010; tick(3);
    winStart();
    pulses(5, 4, 2, 2, 0);
    pulses(4, 3, 2, 2, 0);
    tick(3); winEnd(4, "R7", "selected peer line only");

    curReq = "R8";
    trigSel = 3'b100; ch1Filt = 4'd2; tick(6);
    winStart(); pulses(1, 3, 4, 4, 0); tick(8); winEnd(6, "R8", "channel 1 both edges");

    curReq = "R9";
    trigSel = 3'b101; tick(4);
    winStart(); pulses(1, 3, 4, 4, 0); tick(8); winEnd(3, "R9", "channel 1 rising edges");

    curReq = "R10";
    trigSel = 3'b110; ch2Falling = 1; ch2Filt = 4'd3; tick(6);
    winStart(); ch2Pin = 1; tick(10); winEnd(0, "R10", "channel 2 rise ignored with falling polarity");
    winStart(); ch2Pin = 0; tick(10); winEnd(1, "R10", "channel 2 fall counted");
    ch2Falling = 0; tick(4);
    winStart(); pulses(2, 2, 5, 5, 0); tick(8); winEnd(2, "R10", "channel 2 rising polarity");

    curReq = "R11";
    trigSel = 3'b111; extTrigDiv = 2'd1; extTrigFilt = 4'd1; tick(8);
    winStart(); pulses(0, 4, 3, 3, 0); tick(8); winEnd(2, "R11", "conditioned ext trigger in mode 1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule